// File: doc/BRIEF.md
# Single-Level Fast Context Shadow

This block keeps one hidden saved copy of three core registers: the status register, the working register and the bank-select register. When the core vectors to an interrupt of any source or priority, or runs a subroutine call flagged as fast, it raises the save strobe. The block then copies the live register values into its shadow on that clock edge.

When the core runs an interrupt return or a subroutine return flagged as fast, it raises the restore strobe. On the next cycle the block presents the saved values, together with a one-cycle load-enable that tells the core register file to take them. The shadow is one level deep. It cannot be reached by software. Any later save, such as a high-priority interrupt that arrives while a low-priority handler runs, overwrites the earlier copy without any warning.

Top module: `fast_ctx_shadow`

## Requirements
- R1: The shadow holds exactly one copy each of the status (STATUS_W bits), working (WORK_W bits) and bank-select (BANK_W bits) registers, and has no deeper storage.
- R2: When `save_i` is high at a rising clock edge, all three live inputs are captured into the shadow on that edge.
- R3: When `restore_i` is high at a rising edge, `load_en_o` is 1 for exactly the following cycle, and the three restore outputs carry the shadow contents as they stood before that edge.
- R4: A restore leaves the shadow contents unchanged, so a second restore with no save between returns the same values.
- R5: A cycle with `save_i` low leaves the shadow unchanged. A cycle with `restore_i` low, such as a return not flagged as fast, gives `load_en_o` = 0 in the following cycle.
- R6: Synchronous active-high `rst` clears every shadow register, clears `load_en_o` and clears the restore outputs to 0.
- R7: A second save before a restore replaces the first saved copy, so a nested interrupt silently overwrites the earlier context.
- R8: When `save_i` and `restore_i` are high in the same cycle, the restore outputs carry the old shadow contents and the shadow then holds the new live values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| save_i | input | 1 | Capture strobe (interrupt vector or fast call) |
| restore_i | input | 1 | Restore strobe (fast interrupt return or fast subroutine return) |
| live_status_i | input | STATUS_W | Current status register value |
| live_work_i | input | WORK_W | Current working register value |
| live_bank_i | input | BANK_W | Current bank-select register value |
| load_en_o | output | 1 | One-cycle write enable for the core register file |
| rest_status_o | output | STATUS_W | Status value to restore |
| rest_work_o | output | WORK_W | Working value to restore |
| rest_bank_o | output | BANK_W | Bank-select value to restore |

## Verification
The assertions assume that the strobes and live values are synchronous and settle before each rising edge. They also assume that the core never depends on the restore outputs while `load_en_o` is low. Both strobes may be high together, and the assertions allow for that. The bench changes every input half a period away from the active edge. It sweeps all four strobe combinations against computed data patterns, and it reads the restore outputs only in cycles where its own model predicts a load.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned DEF_STATUS_W = 5;
  localparam int unsigned DEF_WORK_W   = 8;
  localparam int unsigned DEF_BANK_W   = 4;

  typedef enum logic [1:0] {
    CTX_STATUS = 2'd0,
    CTX_WORK   = 2'd1,
    CTX_BANK   = 2'd2
  } ctx_field_e;

  localparam int unsigned CTX_FIELDS = 3;
endpackage

// File: rtl/fcs_slot.sv
module fcs_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)        q_r <= '0;
    else if (cap_i) q_r <= d_i;
  end

  assign q_o = q_r;

  // R2: a capture takes the live value
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    cap_i |=> (q_o == $past(d_i)));
  // R5: no capture, no change
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !cap_i |=> $stable(q_o));
  // R6: reset clears the slot
  p_reset_r6: assert property (@(posedge clk)
    rst |=> (q_o == '0));
endmodule

// File: rtl/fcs_restore_stage.sv
module fcs_restore_stage #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restore_i,
  input  logic [W-1:0] shadow_i,
  output logic         load_en_o,
  output logic [W-1:0] data_o
);
  logic         ld_r;
  logic [W-1:0] data_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_r   <= 1'b0;
      data_r <= '0;
    end else begin
      ld_r <= restore_i;
      if (restore_i) data_r <= shadow_i;
    end
  end

  assign load_en_o = ld_r;
  assign data_o    = data_r;

  // R3: one-cycle load after a restore strobe
  p_load_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    restore_i |=> load_en_o);
  // R3 / R8: restored data is the pre-edge shadow
  p_load_data_r3: assert property (@(posedge clk) disable iff (rst)
    restore_i |=> (data_o == $past(shadow_i)));
  // R5: no restore strobe, no load
  p_no_load_r5: assert property (@(posedge clk) disable iff (rst)
    !restore_i |=> !load_en_o);
  // R6: reset clears the load enable
  p_reset_load_r6: assert property (@(posedge clk)
    rst |=> (!load_en_o && data_o == '0));
endmodule

// File: rtl/fast_ctx_shadow.sv
module fast_ctx_shadow
  import fcs_pkg::*;
#(
  parameter int unsigned STATUS_W = DEF_STATUS_W,
  parameter int unsigned WORK_W   = DEF_WORK_W,
  parameter int unsigned BANK_W   = DEF_BANK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                save_i,
  input  logic                restore_i,
  input  logic [STATUS_W-1:0] live_status_i,
  input  logic [WORK_W-1:0]   live_work_i,
  input  logic [BANK_W-1:0]   live_bank_i,
  output logic                load_en_o,
  output logic [STATUS_W-1:0] rest_status_o,
  output logic [WORK_W-1:0]   rest_work_o,
  output logic [BANK_W-1:0]   rest_bank_o
);
  localparam int unsigned TOT_W = STATUS_W + WORK_W + BANK_W;

  logic [STATUS_W-1:0] sh_status;
  logic [WORK_W-1:0]   sh_work;
  logic [BANK_W-1:0]   sh_bank;
  logic [TOT_W-1:0]    sh_flat;
  logic [TOT_W-1:0]    out_flat;

  // R1: one slot per register, no depth
  fcs_slot #(.W(STATUS_W)) u_status (
    .clk(clk), .rst(rst), .cap_i(save_i), .d_i(live_status_i), .q_o(sh_status));
  fcs_slot #(.W(WORK_W)) u_work (
    .clk(clk), .rst(rst), .cap_i(save_i), .d_i(live_work_i), .q_o(sh_work));
  fcs_slot #(.W(BANK_W)) u_bank (
    .clk(clk), .rst(rst), .cap_i(save_i), .d_i(live_bank_i), .q_o(sh_bank));

  assign sh_flat = {sh_status, sh_work, sh_bank};

  fcs_restore_stage #(.W(TOT_W)) u_restore (
    .clk(clk), .rst(rst), .restore_i(restore_i), .shadow_i(sh_flat),
    .load_en_o(load_en_o), .data_o(out_flat));

  assign rest_status_o = out_flat[TOT_W-1 -: STATUS_W];
  assign rest_work_o   = out_flat[BANK_W +: WORK_W];
  assign rest_bank_o   = out_flat[BANK_W-1:0];

  // R8: simultaneous strobes restore old content while capturing new
  p_same_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    (save_i && restore_i) |=>
      ({rest_status_o, rest_work_o, rest_bank_o} == $past(sh_flat)) &&
      (sh_flat == $past({live_status_i, live_work_i, live_bank_i})));
  // R4: a restore alone leaves the shadow intact
  p_restore_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (restore_i && !save_i) |=> $stable(sh_flat));
endmodule

// File: tb/fast_ctx_shadow_tb.sv
module fast_ctx_shadow_tb;
  localparam int SW = 5, DW = 8, BW = 4;

  logic clk = 1'b0, rst = 1'b1, save_i = 1'b0, restore_i = 1'b0;
  logic [SW-1:0] st_i = '0;
  logic [DW-1:0] wk_i = '0;
  logic [BW-1:0] bk_i = '0;
  logic load_en_o;
  logic [SW-1:0] st_o;
  logic [DW-1:0] wk_o;
  logic [BW-1:0] bk_o;

  int n_chk = 0, n_fail = 0;
  logic [SW+DW+BW-1:0] m_sh;
  logic [SW+DW+BW-1:0] m_out;
  logic m_ld;

  fast_ctx_shadow #(.STATUS_W(SW), .WORK_W(DW), .BANK_W(BW)) u_dut (
    .clk(clk), .rst(rst), .save_i(save_i), .restore_i(restore_i),
    .live_status_i(st_i), .live_work_i(wk_i), .live_bank_i(bk_i),
    .load_en_o(load_en_o), .rest_status_o(st_o), .rest_work_o(wk_o),
    .rest_bank_o(bk_o));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, then check outputs at the next negedge
  task automatic step(input bit s, input bit r, input int pat, input string req);
    logic [SW+DW+BW-1:0] live;
    live = (SW+DW+BW)'(pat * 40503 + 7);
    save_i = s; restore_i = r;
    {st_i, wk_i, bk_i} = live;
    m_ld = r;
    if (r) m_out = m_sh;
    if (s) m_sh = live;
    @(negedge clk);
    chk(load_en_o == m_ld, req, load_en_o, m_ld);
    if (m_ld) chk({st_o, wk_o, bk_o} == m_out, req, {st_o, wk_o, bk_o}, m_out);
  endtask

  initial begin
    m_sh = '0; m_out = '0; m_ld = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6: reset state
    chk(load_en_o == 1'b0, "R6", load_en_o, 0);
    chk({st_o, wk_o, bk_o} == '0, "R6", {st_o, wk_o, bk_o}, 0);
    step(1'b0, 1'b1, 5, "R6");            // restore before any save returns zeros
    // R2 / R3: save then restore
    step(1'b1, 1'b0, 11, "R2");
    step(1'b0, 1'b0, 12, "R5");           // non-fast return: no load
    step(1'b0, 1'b1, 13, "R3");
    step(1'b0, 1'b1, 14, "R4");           // second restore same values
    // R7: nested save overwrites
    step(1'b1, 1'b0, 21, "R7");
    step(1'b1, 1'b0, 22, "R7");
    step(1'b0, 1'b1, 23, "R7");
    // R8: simultaneous strobes
    step(1'b1, 1'b1, 31, "R8");
    step(1'b0, 1'b1, 32, "R8");
    // R1 / R5: sweep all strobe combinations over computed patterns
    for (int i = 0; i < 512; i++)
      step(i[0], i[1] ^ i[3], i + 100, (i[0] & (i[1] ^ i[3])) ? "R8" : "R1");
    // R6: reset mid-run clears shadow
    step(1'b1, 1'b0, 777, "R2");
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_sh = '0; m_out = '0;
    chk(load_en_o == 1'b0, "R6", load_en_o, 0);
    step(1'b0, 1'b1, 778, "R6");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=1 exp=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule